// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides what happens to one received CAN frame, given only its identifier. It holds two small ordered lists of filter entries in internal registers: one list for 11-bit standard identifiers and one for 29-bit extended identifiers. On a start strobe it latches the identifier and the extended flag. It then walks the list that matches the frame type, one entry per clock cycle, from index 0 upwards.

Each entry pairs a comparison kind with an action. The comparison kinds are an inclusive range, two exact values, a value with a care-mask, and, for extended entries only, a range that skips the global mask. The action either ends the scan with a verdict or only marks the frame as high priority and lets the scan go on. When no entry ends the scan, a per-frame-type default verdict applies.

When the scan ends, a one-cycle `done` pulse appears. With it come the destination (drop, queue 0 or queue 1), a priority flag, a two-bit storage indicator, the index of the deciding entry, whether an entry or the default decided, and which list was used. These results hold until the next scan ends. Entries are loaded through a simple word-write port. The list lengths, the defaults and the global extended mask are static inputs.

Top module: `canid_accept_filter`

## Requirements
- R1: A standard entry is one 32-bit word with the kind in bits 31:30, the action in bits 29:27, value A in bits 26:16 and value B in bits 10:0. Kind 0 matches when A <= id <= B, both ends included.
- R2: Kind 1 matches when the identifier equals A or equals B.
- R3: Kind 2 matches when the identifier equals A in every bit position where B holds a 1.
- R4: A standard entry of kind 3 never matches. An entry of any list with action 0 or action 7 never matches.
- R5: Actions 1, 2 and 3 end the scan at the first matching entry in index order, with destination queue 0 (dest=1), queue 1 (dest=2) or drop (dest=0), and without priority.
- R6: Action 4 sets the priority flag and the scan continues. Actions 5 and 6 end the scan with priority and destination queue 0 or queue 1.
- R7: An extended entry is two words. Word 0 holds the action in bits 31:29 and A in bits 28:0. Word 1 holds the kind in bits 31:30 and B in bits 28:0. For kinds 0 to 2 the identifier is ANDed with `xid_mask` before it is compared.
- R8: Extended kind 3 is an inclusive range test on the unmasked identifier.
- R9: Standard frames are checked only against the standard list, and extended frames only against the extended list. Entries at or above the list length (clamped to the list depth) are skipped.
- R10: If no entry ends the scan, the frame type's default code applies: 1 = queue 0, 2 = queue 1, 0 or 3 = drop. Any priority mark collected during the scan is kept.
- R11: `store_ind` is 0 without priority, 1 for a priority frame that is dropped, 2 for one stored in queue 0 and 3 for one stored in queue 1. `filt_idx` and `by_filter=1` give the ending entry. On a default verdict, `by_filter=0` and `filt_idx` is the last priority-marking entry, or 0 if there is none.
- R12: After reset all outputs are 0. The scan evaluates one entry per cycle, so `done` rises k+1 clock edges after the edge that takes the start strobe. Here k is the index of the ending entry, or the list length when no entry ends the scan. `done` lasts one cycle, and the results hold until the next scan ends.
- R13: A start strobe that arrives while a scan is in progress is ignored and does not disturb the current scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_ext | input | 1 | Write target list: 0 standard, 1 extended |
| cfg_word | input | 1 | Extended entry word select (0 or 1) |
| cfg_idx | input | 5 | Entry index to write |
| cfg_data | input | 32 | Entry word data |
| std_len | input | 6 | Number of active standard entries |
| ext_len | input | 6 | Number of active extended entries |
| std_default | input | 2 | Default verdict code for standard frames |
| ext_default | input | 2 | Default verdict code for extended frames |
| xid_mask | input | 29 | Global extended identifier mask |
| start | input | 1 | Begin a scan of the presented identifier |
| rx_id | input | 29 | Received identifier (bits 10:0 for standard) |
| rx_ext | input | 1 | Identifier is extended |
| done | output | 1 | One-cycle result strobe |
| dest | output | 2 | 0 drop, 1 queue 0, 2 queue 1 |
| prio | output | 1 | Frame marked high priority |
| store_ind | output | 2 | Priority storage indicator |
| filt_idx | output | 5 | Deciding entry index |
| from_ext | output | 1 | Result came from the extended list |
| by_filter | output | 1 | An entry, not the default, decided |

## Verification
The assertions assume that `start` is a single-cycle strobe. They also assume that the list lengths, defaults, mask and entry contents stay unchanged while a scan runs. The timing checks count on a scan that ends within the clamped list length. The stimulus writes all configuration and entries only between scans. It raises `start` for one cycle per scan, except in the deliberate second strobe that tests R13, which falls while the block is busy.

// File: rtl/canid_filt_pkg.sv
package canid_filt_pkg;

  localparam int IDX_W = 5;
  localparam int CNT_W = IDX_W + 1;
  localparam int XID_W = 29;

  typedef enum logic [1:0] {
    DST_DROP = 2'd0,
    DST_Q0   = 2'd1,
    DST_Q1   = 2'd2
  } dst_e;

  typedef struct packed {
    logic stop;
    logic mark;
    dst_e dst;
  } verdict_t;

  // Actions 0 and 7 disable an entry.
  function automatic logic act_live(input logic [2:0] a);
    return (a != 3'd0) && (a != 3'd7);
  endfunction

  function automatic verdict_t act_decode(input logic [2:0] a);
    verdict_t v;
    v.stop = 1'b1;
    v.mark = 1'b0;
    v.dst  = DST_DROP;
    case (a)
      3'd1: v.dst = DST_Q0;
      3'd2: v.dst = DST_Q1;
      3'd3: v.dst = DST_DROP;
      3'd4: begin v.stop = 1'b0; v.mark = 1'b1; end
      3'd5: begin v.mark = 1'b1; v.dst = DST_Q0; end
      3'd6: begin v.mark = 1'b1; v.dst = DST_Q1; end
      default: v.stop = 1'b0;
    endcase
    return v;
  endfunction

  // Comparison kinds on a zero-extended identifier.
  function automatic logic kind_hit(input logic [1:0] kind,
                                    input logic [XID_W-1:0] x,
                                    input logic [XID_W-1:0] a,
                                    input logic [XID_W-1:0] b);
    case (kind)
      2'd0:    return (x >= a) && (x <= b);
      2'd1:    return (x == a) || (x == b);
      2'd2:    return ((x ^ a) & b) == '0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic dst_e dflt_map(input logic [1:0] code);
    case (code)
      2'd1:    return DST_Q0;
      2'd2:    return DST_Q1;
      default: return DST_DROP;
    endcase
  endfunction

  function automatic logic [1:0] si_code(input logic p, input dst_e d);
    if (!p) return 2'd0;
    case (d)
      DST_Q0:  return 2'd2;
      DST_Q1:  return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/canid_entry_judge.sv
module canid_entry_judge
  import canid_filt_pkg::*;
(
  input  logic             frm_ext,
  input  logic [XID_W-1:0] frm_id,
  input  logic [XID_W-1:0] xid_mask,
  input  logic [31:0]      std_word,
  input  logic [31:0]      ext_w0,
  input  logic [31:0]      ext_w1,
  output logic             hit,
  output verdict_t         verdict
);

  localparam int PAD_W = XID_W - 11;

  logic [1:0]       s_kind, x_kind;
  logic [2:0]       s_act, x_act;
  logic [XID_W-1:0] s_a, s_b, s_x;
  logic             s_hit, x_hit;
  logic             unused_bits;

  assign unused_bits = ^{std_word[15:11], ext_w1[29]};

  always_comb begin
    s_kind = std_word[31:30];
    s_act  = std_word[29:27];
    s_a    = {{PAD_W{1'b0}}, std_word[26:16]};
    s_b    = {{PAD_W{1'b0}}, std_word[10:0]};
    s_x    = {{PAD_W{1'b0}}, frm_id[10:0]};
    s_hit  = act_live(s_act) && (s_kind != 2'd3) && kind_hit(s_kind, s_x, s_a, s_b);
  end

  always_comb begin
    x_act  = ext_w0[31:29];
    x_kind = ext_w1[31:30];
    if (x_kind == 2'd3)
      x_hit = act_live(x_act) && kind_hit(2'd0, frm_id, ext_w0[28:0], ext_w1[28:0]);
    else
      x_hit = act_live(x_act) &&
              kind_hit(x_kind, frm_id & xid_mask, ext_w0[28:0], ext_w1[28:0]);
  end

  always_comb begin
    hit     = frm_ext ? x_hit : s_hit;
    verdict = act_decode(frm_ext ? x_act : s_act);
  end

endmodule

// File: rtl/canid_entry_bank.sv
module canid_entry_bank
  import canid_filt_pkg::*;
#(
  parameter int STD_DEPTH = 8,
  parameter int EXT_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_ext,
  input  logic             wr_word,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      std_word,
  output logic [31:0]      ext_w0,
  output logic [31:0]      ext_w1
);

  logic [31:0] std_q [STD_DEPTH];
  logic [31:0] x0_q  [EXT_DEPTH];
  logic [31:0] x1_q  [EXT_DEPTH];

  for (genvar i = 0; i < STD_DEPTH; i++) begin : g_std
    always_ff @(posedge clk) begin
      if (!rst_n)
        std_q[i] <= '0;
      else if (wr_en && !wr_ext && (wr_idx == IDX_W'(i)))
        std_q[i] <= wr_data;
    end
  end

  for (genvar i = 0; i < EXT_DEPTH; i++) begin : g_ext
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        x0_q[i] <= '0;
        x1_q[i] <= '0;
      end else if (wr_en && wr_ext && (wr_idx == IDX_W'(i))) begin
        if (wr_word) x1_q[i] <= wr_data;
        else         x0_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    std_word = '0;
    for (int i = 0; i < STD_DEPTH; i++)
      if (rd_idx == IDX_W'(i)) std_word = std_q[i];
  end

  always_comb begin
    ext_w0 = '0;
    ext_w1 = '0;
    for (int i = 0; i < EXT_DEPTH; i++)
      if (rd_idx == IDX_W'(i)) begin
        ext_w0 = x0_q[i];
        ext_w1 = x1_q[i];
      end
  end

endmodule

// File: rtl/canid_scan_ctrl.sv
module canid_scan_ctrl
  import canid_filt_pkg::*;
#(
  parameter int STD_DEPTH = 8,
  parameter int EXT_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [XID_W-1:0] rx_id,
  input  logic             rx_ext,
  input  logic [CNT_W-1:0] std_len,
  input  logic [CNT_W-1:0] ext_len,
  input  logic [1:0]       std_default,
  input  logic [1:0]       ext_default,
  input  logic             hit,
  input  verdict_t         verdict,
  output logic [XID_W-1:0] frm_id,
  output logic             frm_ext,
  output logic [CNT_W-1:0] scan_idx,
  output logic             busy,
  output logic             scan_end,
  output logic             done,
  output logic [1:0]       dest,
  output logic             prio,
  output logic [1:0]       store_ind,
  output logic [IDX_W-1:0] filt_idx,
  output logic             from_ext,
  output logic             by_filter
);

  localparam logic [CNT_W-1:0] STD_CAP = CNT_W'(STD_DEPTH);
  localparam logic [CNT_W-1:0] EXT_CAP = CNT_W'(EXT_DEPTH);

  logic [CNT_W-1:0] lim;
  logic             in_range, live_hit, fin_match, fin_end, mark_ev;
  logic             prio_acc;
  logic [IDX_W-1:0] mark_idx;
  dst_e             def_dst;
  logic             fin_prio;

  always_comb begin
    if (frm_ext) lim = (ext_len > EXT_CAP) ? EXT_CAP : ext_len;
    else         lim = (std_len > STD_CAP) ? STD_CAP : std_len;
    in_range  = scan_idx < lim;
    live_hit  = busy && in_range && hit;
    fin_match = live_hit && verdict.stop;
    fin_end   = busy && !in_range;
    scan_end  = fin_match || fin_end;
    mark_ev   = live_hit && !verdict.stop && verdict.mark;
    def_dst   = dflt_map(frm_ext ? ext_default : std_default);
    fin_prio  = prio_acc || (fin_match && verdict.mark);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      frm_id    <= '0;
      frm_ext   <= 1'b0;
      scan_idx  <= '0;
      prio_acc  <= 1'b0;
      mark_idx  <= '0;
      dest      <= DST_DROP;
      prio      <= 1'b0;
      store_ind <= 2'd0;
      filt_idx  <= '0;
      from_ext  <= 1'b0;
      by_filter <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          frm_id   <= rx_id;
          frm_ext  <= rx_ext;
          scan_idx <= '0;
          prio_acc <= 1'b0;
          mark_idx <= '0;
        end
      end else begin
        if (mark_ev) begin
          prio_acc <= 1'b1;
          mark_idx <= scan_idx[IDX_W-1:0];
        end
        if (scan_end) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          prio     <= fin_prio;
          from_ext <= frm_ext;
          if (fin_match) begin
            dest      <= verdict.dst;
            store_ind <= si_code(fin_prio, verdict.dst);
            filt_idx  <= scan_idx[IDX_W-1:0];
            by_filter <= 1'b1;
          end else begin
            dest      <= def_dst;
            store_ind <= si_code(fin_prio, def_dst);
            filt_idx  <= mark_idx;
            by_filter <= 1'b0;
          end
        end else begin
          scan_idx <= scan_idx + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/canid_accept_filter.sv
module canid_accept_filter
  import canid_filt_pkg::*;
#(
  parameter int STD_DEPTH = 8,
  parameter int EXT_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_ext,
  input  logic        cfg_word,
  input  logic [4:0]  cfg_idx,
  input  logic [31:0] cfg_data,
  input  logic [5:0]  std_len,
  input  logic [5:0]  ext_len,
  input  logic [1:0]  std_default,
  input  logic [1:0]  ext_default,
  input  logic [28:0] xid_mask,
  input  logic        start,
  input  logic [28:0] rx_id,
  input  logic        rx_ext,
  output logic        done,
  output logic [1:0]  dest,
  output logic        prio,
  output logic [1:0]  store_ind,
  output logic [4:0]  filt_idx,
  output logic        from_ext,
  output logic        by_filter
);

  logic [XID_W-1:0] frm_id;
  logic             frm_ext;
  logic [CNT_W-1:0] scan_idx;
  logic             busy, scan_end, hit;
  verdict_t         verdict;
  logic [31:0]      std_word, ext_w0, ext_w1;

  canid_entry_bank #(.STD_DEPTH(STD_DEPTH), .EXT_DEPTH(EXT_DEPTH)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_ext(cfg_ext), .wr_word(cfg_word),
    .wr_idx(cfg_idx), .wr_data(cfg_data),
    .rd_idx(scan_idx[IDX_W-1:0]),
    .std_word(std_word), .ext_w0(ext_w0), .ext_w1(ext_w1)
  );

  canid_entry_judge u_judge (
    .frm_ext(frm_ext), .frm_id(frm_id), .xid_mask(xid_mask),
    .std_word(std_word), .ext_w0(ext_w0), .ext_w1(ext_w1),
    .hit(hit), .verdict(verdict)
  );

  canid_scan_ctrl #(.STD_DEPTH(STD_DEPTH), .EXT_DEPTH(EXT_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_id(rx_id), .rx_ext(rx_ext),
    .std_len(std_len), .ext_len(ext_len),
    .std_default(std_default), .ext_default(ext_default),
    .hit(hit), .verdict(verdict),
    .frm_id(frm_id), .frm_ext(frm_ext), .scan_idx(scan_idx),
    .busy(busy), .scan_end(scan_end), .done(done), .dest(dest),
    .prio(prio), .store_ind(store_ind), .filt_idx(filt_idx),
    .from_ext(from_ext), .by_filter(by_filter)
  );

endmodule

// File: rtl/canid_accept_filter_chk.sv
module canid_accept_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        scan_end,
  input logic [5:0]  scan_idx,
  input logic [28:0] frm_id,
  input logic        frm_ext,
  input logic        done,
  input logic [1:0]  dest,
  input logic        prio,
  input logic [1:0]  store_ind,
  input logic [4:0]  filt_idx
);

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_one_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !scan_end |=> busy && (scan_idx == $past(scan_idx) + 6'd1));

  p_end_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && scan_end |=> done && !busy);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(dest) && $stable(prio) && $stable(filt_idx)
                        && $stable(store_ind));

  p_ignore_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(frm_id) && $stable(frm_ext));

  p_si_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((store_ind == 2'd0) == !prio));

  p_si_q0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && (store_ind == 2'd2) |-> (dest == 2'd1));

  p_si_q1_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && (store_ind == 2'd3) |-> (dest == 2'd2));

endmodule

bind canid_accept_filter canid_accept_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .scan_end(scan_end),
  .scan_idx(scan_idx), .frm_id(frm_id), .frm_ext(frm_ext), .done(done),
  .dest(dest), .prio(prio), .store_ind(store_ind), .filt_idx(filt_idx)
);

// File: tb/canid_accept_filter_tb.sv
`timescale 1ns/1ps
module canid_accept_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_ext = 1'b0, cfg_word = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic [5:0]  std_len = '0, ext_len = '0;
  logic [1:0]  std_default = '0, ext_default = '0;
  logic [28:0] xid_mask = '0;
  logic        start = 1'b0;
  logic [28:0] rx_id = '0;
  logic        rx_ext = 1'b0;
  logic        done, prio, from_ext, by_filter;
  logic [1:0]  dest, store_ind;
  logic [4:0]  filt_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  canid_accept_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ext(cfg_ext),
    .cfg_word(cfg_word), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .std_len(std_len), .ext_len(ext_len), .std_default(std_default),
    .ext_default(ext_default), .xid_mask(xid_mask), .start(start),
    .rx_id(rx_id), .rx_ext(rx_ext), .done(done), .dest(dest), .prio(prio),
    .store_ind(store_ind), .filt_idx(filt_idx), .from_ext(from_ext),
    .by_filter(by_filter)
  );

  // Bench-side picture of the lists, kept as separate fields.
  int          m_skind [8], m_sact [8];
  logic [10:0] m_sa [8], m_sb [8];
  int          m_xkind [8], m_xact [8];
  logic [28:0] m_xa [8], m_xb [8];
  int          m_slen = 0, m_xlen = 0, m_sdef = 0, m_xdef = 0;
  logic [28:0] m_gm = '0;

  int e_dest, e_prio, e_idx, e_byf, e_si, e_lat;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit bmatch(input int kind, input logic [28:0] x,
                                input logic [28:0] a, input logic [28:0] b,
                                input int nb);
    bit ok;
    if (kind == 0) return (a <= x) && (x <= b);
    if (kind == 1) return (x == a) || (x == b);
    ok = 1;
    for (int j = 0; j < nb; j++)
      if (b[j] && (x[j] != a[j])) ok = 0;
    return ok;
  endfunction

  function automatic void predict(input logic [28:0] id, input bit ext);
    int lim, kind, act, stop_at, pr, pidx;
    bit h;
    logic [28:0] x, a, b;
    lim = ext ? m_xlen : m_slen;
    if (lim > 8) lim = 8;
    stop_at = -1; pr = 0; pidx = 0; act = 0;
    for (int i = 0; i < lim; i++) begin
      if (stop_at < 0) begin
        if (ext) begin
          kind = m_xkind[i]; act = m_xact[i]; a = m_xa[i]; b = m_xb[i]; x = id;
          h = (kind == 3) ? bmatch(0, x, a, b, 29) : bmatch(kind, x & m_gm, a, b, 29);
        end else begin
          kind = m_skind[i]; act = m_sact[i];
          a = {18'd0, m_sa[i]}; b = {18'd0, m_sb[i]}; x = {18'd0, id[10:0]};
          h = (kind == 3) ? 1'b0 : bmatch(kind, x, a, b, 11);
        end
        if (act == 0 || act == 7) h = 0;
        if (h) begin
          if (act == 4) begin pr = 1; pidx = i; end
          else stop_at = i;
        end
      end
    end
    if (stop_at >= 0) begin
      act = ext ? m_xact[stop_at] : m_sact[stop_at];
      e_dest = (act == 1 || act == 5) ? 1 : (act == 2 || act == 6) ? 2 : 0;
      e_prio = (pr != 0 || act >= 5) ? 1 : 0;
      e_idx = stop_at; e_byf = 1; e_lat = stop_at + 2;
    end else begin
      kind = ext ? m_xdef : m_sdef;
      e_dest = (kind == 1) ? 1 : (kind == 2) ? 2 : 0;
      e_prio = pr; e_idx = pidx; e_byf = 0; e_lat = lim + 2;
    end
    e_si = (e_prio == 0) ? 0 : (e_dest == 0) ? 1 : (e_dest == 1) ? 2 : 3;
  endfunction

  task automatic wr_std(input int i, input int kind, input int act,
                        input logic [10:0] a, input logic [10:0] b);
    logic [1:0] k2 = kind[1:0];
    logic [2:0] a3 = act[2:0];
    m_skind[i] = kind; m_sact[i] = act; m_sa[i] = a; m_sb[i] = b;
    @(negedge clk);
    cfg_we = 1; cfg_ext = 0; cfg_word = 0; cfg_idx = i[4:0];
    cfg_data = {k2, a3, a, 5'd0, b};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_ext(input int i, input int kind, input int act,
                        input logic [28:0] a, input logic [28:0] b);
    logic [1:0] k2 = kind[1:0];
    logic [2:0] a3 = act[2:0];
    m_xkind[i] = kind; m_xact[i] = act; m_xa[i] = a; m_xb[i] = b;
    @(negedge clk);
    cfg_we = 1; cfg_ext = 1; cfg_word = 0; cfg_idx = i[4:0]; cfg_data = {a3, a};
    @(negedge clk);
    cfg_word = 1; cfg_data = {k2, 1'b0, b};
    @(negedge clk);
    cfg_we = 0; cfg_word = 0;
  endtask

  task automatic set_cfg(input int sl, input int xl, input int sd, input int xd,
                         input logic [28:0] gm);
    @(negedge clk);
    std_len = sl[5:0]; ext_len = xl[5:0]; std_default = sd[1:0];
    ext_default = xd[1:0]; xid_mask = gm;
    m_slen = sl; m_xlen = xl; m_sdef = sd; m_xdef = xd; m_gm = gm;
  endtask

  task automatic scan(input logic [28:0] id, input bit ext, input string tag,
                      input bit poke);
    int cyc;
    logic [1:0] d_hold;
    predict(id, ext);
    @(negedge clk);
    rx_id = id; rx_ext = ext; start = 1;
    @(negedge clk);
    start = poke; rx_id = ~id; rx_ext = ~ext;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      start = 0;
      cyc++;
    end
    start = 0;
    chk(done == 1'b1, tag, "done seen", done, 1);
    chk(dest == e_dest[1:0], tag, "dest", dest, e_dest);
    chk(prio == e_prio[0], "R6", "prio", prio, e_prio);
    chk(store_ind == e_si[1:0], "R11", "store_ind", store_ind, e_si);
    chk(filt_idx == e_idx[4:0], "R11", "filt_idx", filt_idx, e_idx);
    chk(by_filter == e_byf[0], "R11", "by_filter", by_filter, e_byf);
    chk(from_ext == ext, "R9", "from_ext", from_ext, ext);
    chk(cyc == e_lat, poke ? "R13" : "R12", "latency", cyc, e_lat);
    d_hold = dest;
    @(negedge clk);
    chk(!done && dest == d_hold, "R12", "pulse and hold", {done, dest}, {1'b0, d_hold});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not end actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [28:0] r;
    for (int i = 0; i < 8; i++) begin
      m_skind[i] = 0; m_sact[i] = 0; m_sa[i] = '0; m_sb[i] = '0;
      m_xkind[i] = 0; m_xact[i] = 0; m_xa[i] = '0; m_xb[i] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk({done, dest, prio, store_ind, filt_idx, from_ext, by_filter} == '0,
        "R12", "reset outputs",
        {done, dest, prio, store_ind, filt_idx, from_ext, by_filter}, 0);

    // Standard list
    wr_std(0, 0, 1, 11'h100, 11'h10F);
    wr_std(1, 1, 2, 11'h200, 11'h3FF);
    wr_std(2, 2, 3, 11'h450, 11'h7F0);
    wr_std(3, 0, 4, 11'h400, 11'h5FF);
    wr_std(4, 1, 5, 11'h480, 11'h500);
    wr_std(5, 0, 6, 11'h5F0, 11'h5FF);
    wr_std(6, 3, 1, 11'h000, 11'h7FF);
    wr_std(7, 0, 7, 11'h000, 11'h7FF);
    set_cfg(8, 4, 2, 1, 29'h1FFF_FFF0);

    scan(29'h100, 0, "R1", 0);
    scan(29'h10F, 0, "R1", 0);
    scan(29'h110, 0, "R1", 0);
    scan(29'h3FF, 0, "R2", 0);
    scan(29'h201, 0, "R2", 0);
    scan(29'h45A, 0, "R3", 0);
    scan(29'h46A, 0, "R3", 0);
    scan(29'h7F0, 0, "R4", 0);
    scan(29'h480, 0, "R6", 0);
    scan(29'h5F8, 0, "R6", 0);
    scan(29'h420, 0, "R10", 0);
    for (int id = 0; id < 2048; id++) scan(29'(id), 0, "R5", 0);

    // Extended list
    wr_ext(0, 0, 1, 29'h0000_1000, 29'h0000_10FF);
    wr_ext(1, 3, 2, 29'h0000_2003, 29'h0000_2005);
    wr_ext(2, 2, 6, 29'h1ABC_DE00, 29'h1FFF_FF00);
    wr_ext(3, 1, 3, 29'h0000_0F00, 29'h1FFF_FFF0);
    scan(29'h0000_10FA, 1, "R7", 0);
    scan(29'h0000_0F0C, 1, "R7", 0);
    scan(29'h0000_2004, 1, "R8", 0);
    scan(29'h0000_2000, 1, "R8", 0);
    scan(29'h1ABC_DE55, 1, "R6", 0);
    scan(29'h0000_03FF, 1, "R9", 0);
    scan(29'h0000_0000, 1, "R10", 0);
    for (int k = 0; k < 256; k++) scan(29'h2000 + 29'(k), 1, "R8", 0);
    for (int k = 0; k < 256; k++) scan(29'h1000 + 29'(k * 3), 1, "R7", 0);
    for (int k = 0; k < 64; k++) scan(29'h1ABC_DE00 + 29'(k * 5), 1, "R7", 0);
    r = 29'h0123_4567;
    for (int k = 0; k < 128; k++) begin
      r = {r[27:0], r[28] ^ r[26]};
      scan(r, 1, "R7", 0);
    end

    // Start strobe while busy
    scan(29'h5F5, 0, "R13", 1);
    scan(29'h000, 1, "R13", 1);

    // Shorter list, disabled action, drop default
    wr_std(1, 1, 0, 11'h200, 11'h3FF);
    set_cfg(3, 4, 3, 1, 29'h1FFF_FFF0);
    scan(29'h200, 0, "R4", 0);
    scan(29'h480, 0, "R9", 0);
    for (int id = 0; id < 2048; id++) scan(29'(id), 0, "R9", 0);

    set_cfg(0, 4, 0, 1, 29'h1FFF_FFF0);
    scan(29'h100, 0, "R10", 0);
    set_cfg(40, 4, 2, 1, 29'h1FFF_FFF0);
    scan(29'h7F0, 0, "R9", 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule